// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves 8-bit words over a two-line link made of one serial clock line and one serial data line. A small register port holds a transmit word, a receive word, status flags, a half-period setting for the clock divider and a control word. The control word switches the block on, picks its clock role, selects the bit order and sets the level the data line rests at between frames.

As clock master, the block starts a frame when software writes the transmit word. It then generates eight low-going clock pulses from a divider of the system clock. As clock slave, it follows a clock that arrives on `sck_in`. That clock passes through a two-stage synchronizer, and its edges are found in the system clock domain. In both roles each data bit is put on the line at a falling clock edge and stays there until the next falling edge. Incoming data is captured at each rising edge. After the eighth rising edge the assembled word goes into the receive register and the receive-full flag is raised. If the previous word has not yet been read, the overrun flag is raised and the previous word is kept.

Top module: `sst_xcvr`

## Requirements
- R1: After a synchronous reset: `sck_out`=1, `sck_oe`=0, `sda_oe`=0, `sda_out`=1. CTRL (address 0) reads 0x08, DIV (address 4) reads 4 and STAT (address 3) reads 0. Register reads return data in the cycle after `reg_rd`.
- R2: CTRL bit 0 enables the block. While it is 0, no frame starts and a TXD write (address 1) leaves STAT busy (bit 2) at 0. Both output enables stay 0, and `sda_oe` equals the enable bit.
- R3: With CTRL bit 1 set (master), a TXD write while idle starts a frame. `sck_out` idles high and then makes exactly 8 low pulses. Each high phase and each low phase lasts H system cycles, where H is the DIV value, or 4 when DIV is below 4. STAT busy is 1 from the write until the 8th rising edge.
- R4: During a frame, `sda_out` changes only together with a falling edge of the serial clock. It holds each bit through the following rising edge.
- R5: CTRL bit 2 selects bit order: 0 for MSB first, 1 for LSB first. The same order applies to the bits sent and to the bits assembled from received data.
- R6: At the 8th rising edge the received word goes into RXD (address 2) and STAT bit 0 (receive full) is set in the same cycle that busy clears. Reading RXD clears STAT bit 0.
- R7: If a frame completes while STAT bit 0 is set and RXD is not being read in that cycle, STAT bit 1 (overrun) is set and RXD keeps the older word. Writing STAT with bit 1 = 1 clears the overrun flag.
- R8: While no frame is shifting, `sda_out` equals CTRL bit 3.
- R9: With CTRL bit 1 clear (slave), `sck_oe` is 0 and frames run on the clock from `sck_in`. The first falling edge loads TXD and sets busy. Transmit bits follow falling edges and received bits are taken at rising edges, and the frame completes after 8 rising edges.
- R10: CTRL writes are ignored while STAT busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 CTRL, 1 TXD, 2 RXD, 3 STAT, 4 DIV |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| sck_in | input | 1 | External serial clock (slave role) |
| sck_out | output | 1 | Generated serial clock (master role), high when idle |
| sck_oe | output | 1 | Serial clock output enable |
| sda_in | input | 1 | Serial data input |
| sda_out | output | 1 | Serial data output |
| sda_oe | output | 1 | Serial data output enable |

## Verification
The assertions check the following on every cycle: the serial clock stays high outside a frame, and the data line moves only on a falling clock edge while a master frame runs. They also check that receive-full rises exactly when busy falls, that RXD stays put while an unread word is held, that overrun rises only over a full register, that busy never appears while the block is disabled, and that the control word stays frozen during a frame. Only the bench's scenarios can show the rest: the exact high and low phase lengths for each divider value, the bit sequence on the line, the words assembled under both bit orders in both clock roles, the idle level, and the readback values after an overrun.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;

  // control word, bit 0 is the enable
  typedef struct packed {
    logic idle;   // bit 3: data line level between frames
    logic lsb;    // bit 2: 1 = LSB first
    logic mst;    // bit 1: 1 = drive the serial clock
    logic en;     // bit 0: block enable
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{idle: 1'b1, lsb: 1'b0, mst: 1'b0, en: 1'b0};
endpackage

// File: rtl/sst_clkdiv.sv
module sst_clkdiv #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sck,
  output logic             fall_ev,
  output logic             rise_ev
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             tick;

  always_comb begin
    lim = (half < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half;
  end

  assign tick    = run && (cnt == lim - 1'b1);
  assign fall_ev = tick && sck;
  assign rise_ev = tick && !sck;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sst_insync.sv
module sst_insync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_pin,
  input  logic sda_pin,
  output logic sda_s,
  output logic fall_ev,
  output logic rise_ev
);
  logic [SYNC_N:0]   sck_r;
  logic [SYNC_N-1:0] sda_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_r <= '1;
      sda_r <= '1;
    end else begin
      sck_r <= {sck_r[SYNC_N-1:0], sck_pin};
      sda_r <= {sda_r[SYNC_N-2:0], sda_pin};
    end
  end

  // data and clock leave the chain at the same depth
  assign sda_s   = sda_r[SYNC_N-1];
  assign fall_ev = sck_r[SYNC_N] & ~sck_r[SYNC_N-1];
  assign rise_ev = ~sck_r[SYNC_N] & sck_r[SYNC_N-1];
endmodule

// File: rtl/sst_shift.sv
module sst_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic         lsb,
  input  logic [W-1:0] tx_word,
  input  logic         sda_s,
  output logic         bit_q,
  output logic         first,
  output logic         done,
  output logic         in_frame,
  output logic [W-1:0] rx_next
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  tx_sr;
  logic [W-1:0]  rx_sr;
  logic [CW-1:0] nfall;
  logic [CW-1:0] nrise;
  logic [W-1:0]  src;
  logic          take_fall;
  logic          take_rise;

  assign in_frame  = (nfall != '0);
  assign src       = in_frame ? tx_sr : tx_word;
  assign take_fall = fall_ev && (nfall != CW'(W));
  assign take_rise = rise_ev && in_frame;
  assign first     = fall_ev && !in_frame;
  assign done      = take_rise && (nrise == CW'(W - 1));
  assign rx_next   = lsb ? {sda_s, rx_sr[W-1:1]} : {rx_sr[W-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_sr <= '0;
      nfall <= '0;
      nrise <= '0;
      bit_q <= 1'b1;
    end else begin
      if (take_fall) begin
        bit_q <= lsb ? src[0] : src[W-1];
        tx_sr <= lsb ? (src >> 1) : (src << 1);
        nfall <= nfall + 1'b1;
      end
      if (take_rise) begin
        rx_sr <= rx_next;
        if (done) begin
          nrise <= '0;
          nfall <= '0;
        end else begin
          nrise <= nrise + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sst_xcvr.sv
module sst_xcvr
  import sst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sda_in,
  output logic              sda_out,
  output logic              sda_oe
);
  // sampled data must have crossed the synchronizer before the rising edge
  localparam int MIN_HALF = SYNC_N + 2;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] txd_q;
  logic [DATA_W-1:0] rxd_q;
  logic [DIV_W-1:0]  half_q;
  logic              full_q;
  logic              ovr_q;
  logic              busy_q;

  logic wr_ctrl, wr_txd, wr_stat, wr_div, rd_rx;
  logic start_m;
  logic cg_sck, cg_fall, cg_rise;
  logic sy_sda, sy_fall, sy_rise;
  logic ev_fall, ev_rise;
  logic sh_bit, sh_first, sh_done, sh_frame;
  logic [DATA_W-1:0] sh_rx;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL) && !busy_q;
  assign wr_txd  = reg_wr && (reg_addr == A_TXD);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_div  = reg_wr && (reg_addr == A_DIV);
  assign rd_rx   = reg_rd && (reg_addr == A_RXD);
  assign start_m = wr_txd && ctrl_q.en && ctrl_q.mst && !busy_q;

  sst_clkdiv #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_div (
    .clk(clk), .rst(rst), .run(busy_q && ctrl_q.mst), .half(half_q),
    .sck(cg_sck), .fall_ev(cg_fall), .rise_ev(cg_rise)
  );

  sst_insync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .sck_pin(sck_in), .sda_pin(sda_in),
    .sda_s(sy_sda), .fall_ev(sy_fall), .rise_ev(sy_rise)
  );

  assign ev_fall = ctrl_q.en && (ctrl_q.mst ? cg_fall : sy_fall);
  assign ev_rise = ctrl_q.en && (ctrl_q.mst ? cg_rise : sy_rise);

  sst_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .fall_ev(ev_fall), .rise_ev(ev_rise),
    .lsb(ctrl_q.lsb), .tx_word(txd_q), .sda_s(sy_sda),
    .bit_q(sh_bit), .first(sh_first), .done(sh_done),
    .in_frame(sh_frame), .rx_next(sh_rx)
  );

  // register file and frame control
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      txd_q  <= '0;
      rxd_q  <= '0;
      half_q <= DIV_W'(MIN_HALF);
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (wr_txd)  txd_q  <= reg_wdata;
      if (wr_div)  half_q <= reg_wdata[DIV_W-1:0];

      if (sh_done)
        busy_q <= 1'b0;
      else if (start_m || (sh_first && !ctrl_q.mst))
        busy_q <= 1'b1;

      if (sh_done) begin
        if (full_q && !rd_rx) begin
          ovr_q <= 1'b1;
        end else begin
          rxd_q  <= sh_rx;
          full_q <= 1'b1;
        end
      end else begin
        if (rd_rx) full_q <= 1'b0;
        if (wr_stat && reg_wdata[1]) ovr_q <= 1'b0;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= DATA_W'(ctrl_q);
        A_TXD:   reg_rdata <= txd_q;
        A_RXD:   reg_rdata <= rxd_q;
        A_STAT:  reg_rdata <= DATA_W'({busy_q, ovr_q, full_q});
        A_DIV:   reg_rdata <= DATA_W'(half_q);
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign sck_out = (ctrl_q.en && ctrl_q.mst) ? cg_sck : 1'b1;
  assign sck_oe  = ctrl_q.en && ctrl_q.mst;
  assign sda_oe  = ctrl_q.en;
  assign sda_out = sh_frame ? sh_bit : ctrl_q.idle;
endmodule

// File: rtl/sst_xcvr_chk.sv
module sst_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sck_out,
  input logic              sda_out,
  input logic              busy,
  input logic [3:0]        ctrl,
  input logic              full,
  input logic              ovr,
  input logic [DATA_W-1:0] rxd,
  input logic              rd_rx
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!busy && !full && !ovr && sck_out));

  assert_enable_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> ctrl[0]);

  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sck_out);

  assert_launch_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl[1] && busy && $past(busy) && !$stable(sda_out)) |-> $fell(sck_out));

  assert_full_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $fell(busy));

  assert_keep_old_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(full) && full && !$past(rd_rx)) |-> $stable(rxd));

  assert_ovr_needs_full_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(full));

  assert_ctrl_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ctrl));
endmodule

bind sst_xcvr sst_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sck_out(sck_out), .sda_out(sda_out),
  .busy(busy_q), .ctrl(ctrl_q), .full(full_q), .ovr(ovr_q),
  .rxd(rxd_q), .rd_rx(rd_rx)
);

// File: tb/test_sst_xcvr.sv
module test_sst_xcvr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sck_drv = 1'b1, sda_drv = 1'b1;
  logic       sck_out, sck_oe, sda_out, sda_oe;
  int         n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  sst_xcvr i_sst_xcvr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_in(sck_drv), .sck_out(sck_out), .sck_oe(sck_oe),
    .sda_in(sda_drv), .sda_out(sda_out), .sda_oe(sda_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // bench acts as slave: drives sda_drv, watches the generated clock
  task automatic master_frame(input logic [7:0] txb, input logic [7:0] rxb,
                              input logic lsb, input logic idle, input int h,
                              input logic exp_ovr);
    logic [7:0] d;
    int cnt;
    wr(3'd0, {4'b0, idle, lsb, 2'b11});
    chk("R8 idle level before frame", sda_out, idle);
    wr(3'd1, txb);
    for (int k = 0; k < 8; k++) begin
      cnt = 0;
      while (sck_out === 1'b1) begin cnt++; @(negedge clk); end
      chk("R3 high phase length", cnt, h);
      chk("R4/R5 master tx bit", sda_out, lsb ? txb[k] : txb[7-k]);
      sda_drv = lsb ? rxb[k] : rxb[7-k];
      cnt = 0;
      while (sck_out === 1'b0) begin cnt++; @(negedge clk); end
      chk("R3 low phase length", cnt, h);
      chk("R4 bit held over rise", sda_out, (k == 7) ? idle : (lsb ? txb[k] : txb[7-k]));
    end
    chk("R8 idle level after frame", sda_out, idle);
    rd(3'd3, d);
    chk("R3/R6/R7 status after master frame", d, {5'b0, 1'b0, exp_ovr, 1'b1});
  endtask

  // bench acts as master on sck_in/sda_in
  task automatic slave_frame(input logic [7:0] txb, input logic [7:0] rxb,
                             input logic lsb, input logic idle, input int h);
    logic [7:0] d;
    wr(3'd0, {4'b0, idle, lsb, 2'b01});
    wr(3'd1, txb);
    chk("R9 sck_oe low in slave role", sck_oe, 1'b0);
    chk("R8 idle level in slave role", sda_out, idle);
    for (int k = 0; k < 8; k++) begin
      sck_drv = 1'b0;
      sda_drv = lsb ? rxb[k] : rxb[7-k];
      repeat (h) @(negedge clk);
      chk("R9/R5 slave tx bit", sda_out, lsb ? txb[k] : txb[7-k]);
      sck_drv = 1'b1;
      if (k == 0) begin
        rd(3'd3, d);
        chk("R9 busy set by first external fall", d[2], 1'b1);
        repeat (h - 1) @(negedge clk);
      end else begin
        repeat (h) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    chk("R8 idle level after slave frame", sda_out, idle);
    rd(3'd3, d);
    chk("R9/R6 status after slave frame", d, 8'h01);
    rd(3'd2, d);
    chk("R9/R5 slave received word", d, rxb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] txb, rxb, prev_rx;
    int dv, h;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 sck_out", sck_out, 1'b1);
    chk("R1 sck_oe", sck_oe, 1'b0);
    chk("R1 sda_oe", sda_oe, 1'b0);
    chk("R1 sda_out", sda_out, 1'b1);
    rd(3'd0, d); chk("R1 CTRL", d, 8'h08);
    rd(3'd4, d); chk("R1 DIV", d, 8'h04);
    rd(3'd3, d); chk("R1 STAT", d, 8'h00);

    // R2 disabled block ignores a transmit write
    wr(3'd0, 8'h0A);
    wr(3'd1, 8'h5A);
    repeat (20) begin
      @(negedge clk);
      chk("R2 no clock while disabled", sck_out, 1'b1);
    end
    chk("R2 sck_oe", sck_oe, 1'b0);
    chk("R2 sda_oe", sda_oe, 1'b0);
    rd(3'd3, d); chk("R2 busy stays low", d, 8'h00);

    // R8 idle level follows the control bit
    wr(3'd0, 8'h03); chk("R8 idle 0", sda_out, 1'b0);
    chk("R2 sda_oe when enabled", sda_oe, 1'b1);
    wr(3'd0, 8'h0B); chk("R8 idle 1", sda_out, 1'b1);

    // R3 R4 R5 R6 master sweep over every word, several divider values
    for (int i = 0; i < 256; i++) begin
      txb = 8'(i);
      rxb = 8'(i * 37 + 11);
      dv  = ((i % 4) == 3) ? 2 : 4 + (i % 3);
      h   = (dv < 4) ? 4 : dv;
      wr(3'd4, 8'(dv));
      master_frame(txb, rxb, txb[0] ^ txb[3], txb[1], h, 1'b0);
      rd(3'd2, d);
      chk("R6/R5 master received word", d, rxb);
      rd(3'd3, d);
      chk("R6 read clears full", d, 8'h00);
    end

    // R7 overrun keeps the older word
    wr(3'd4, 8'd4);
    master_frame(8'h3C, 8'hA7, 1'b0, 1'b1, 4, 1'b0);
    master_frame(8'hC3, 8'h19, 1'b1, 1'b1, 4, 1'b1);
    rd(3'd2, prev_rx);
    chk("R7 older word kept", prev_rx, 8'hA7);
    rd(3'd3, d); chk("R7 overrun stays after read", d, 8'h02);
    wr(3'd3, 8'h02);
    rd(3'd3, d); chk("R7 overrun cleared by write", d, 8'h00);

    // R10 control write during a frame is dropped
    wr(3'd0, 8'h0B);
    wr(3'd1, 8'h81);
    wr(3'd0, 8'h05);
    rd(3'd0, d); chk("R10 CTRL unchanged while busy", d, 8'h0B);
    repeat (90) @(negedge clk);
    rd(3'd3, d); chk("R10 frame completed", d, 8'h01);
    rd(3'd0, d); chk("R10 CTRL after frame", d, 8'h0B);
    rd(3'd2, d);
    wr(3'd0, 8'h05);
    rd(3'd0, d); chk("R10 CTRL write accepted when idle", d, 8'h05);

    // R9 slave sweep
    for (int i = 0; i < 64; i++) begin
      slave_frame(8'(i * 5 + 3), 8'(i * 29 + 1), i[0], i[2], 8);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule